// File: doc/BRIEF.md
# Two-Port Switch Destination Filter

This block decides where a received Ethernet frame goes inside a small switch that has two line ports and one host port. As the first six bytes of a frame arrive from either line port, the block assembles the destination MAC address. It compares that address with a table of masked address entries and produces one decision per frame. The decision says whether the frame is delivered to the host, forwarded to the other line port, or both. It also says whether any entry matched and whether the frame is high priority for the host.

Each entry carries a 48-bit address and a 48-bit mask. It has one apply bit per ingress port and three action bits: to host, to other port, and host priority. When several entries match, their actions are merged. A frame that matches no entry follows per-port rules for unknown destinations. All configuration writes land in a staged copy. The copy used for decisions changes only when software issues a sync command, so that a half-written table never steers traffic.

Top module: `fwd_filter`

## Requirements
- R1: After reset `dec_vld` is low, every entry is disabled and every unknown-destination rule is off, so a frame sent before any configuration yields `dec_fwd` = 00 with `dec_hit` = 0.
- R2: A byte accepted with `rx_sof` high is the most significant byte of the destination address (DA[47:40]), and the next five accepted bytes follow in order. Bytes after the sixth are ignored until the next `rx_sof`. Bytes accepted while no frame is open are ignored. An `rx_sof` restarts assembly.
- R3: `dec_vld` is a one-cycle strobe raised two clock edges after the edge that accepts the sixth address byte (one edge when `PIPE_CMP` = 0). Exactly one strobe is produced per frame.
- R4: An entry matches when ((DA XOR entry address) AND entry mask) is zero over all 48 bits. A mask bit of 0 is a don't-care, and an all-zero mask matches every address.
- R5: In the entry upper word, bit 30 enables the entry for frames from port 1 (`rx_port` = 0) and bit 31 enables it for port 2 (`rx_port` = 1). An entry whose bit for the ingress port is clear never matches.
- R6: If any entry matches, `dec_hit` = 1. `dec_fwd[1]` (host) is the OR of upper-word bit 16 over the matching entries, and `dec_fwd[0]` (other port) is the OR of upper-word bit 17 over the same entries.
- R7: `dec_pri` is the OR of upper-word bit 19 over the matching entries, and it is 0 when nothing matches.
- R8: With no match, `dec_hit` = 0 and `dec_pri` = 0. The host bit takes configuration bit 2 for port 1 and bit 12 for port 2. The other-port bit takes configuration bit 13 for port 1 and bit 14 for port 2.
- R9: Configuration and entry writes have no effect on decisions until a write to the sync address with data bit 15 set. A sync write with bit 15 clear changes nothing.
- R10: The word addresses are: 0x01 sync, 0x02 configuration. Entry i uses 0x10+2i for its upper word (actions plus DA[47:32] in bits 15:0), 0x11+2i for its lower word (DA[31:0]), 0x20+2i for its upper mask (bits 15:0) and 0x21+2i for its lower mask. Writes to any other address are ignored.
- R11: While `dec_vld` is low, `dec_fwd`, `dec_hit` and `dec_pri` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | AW | Configuration word address |
| cfg_wdata | input | 32 | Configuration write data |
| rx_vld | input | 1 | Receive byte valid |
| rx_sof | input | 1 | First byte of a frame |
| rx_port | input | 1 | Ingress port: 0 = port 1, 1 = port 2 |
| rx_byte | input | 8 | Receive byte |
| dec_vld | output | 1 | Decision strobe |
| dec_fwd | output | 2 | Bit 1 = to host, bit 0 = to other port |
| dec_hit | output | 1 | At least one entry matched |
| dec_pri | output | 1 | Host priority |

## Verification
The bench programs the table with random addresses, partial masks and apply bits. It then sends destinations derived from the entry addresses, so that partial-mask matches, multi-entry merges and near misses all occur. A design that reversed the byte order, ignored the mask, or picked one entry instead of merging would report the wrong host or other-port bits. Directed cases cover the staged table before and after sync, and a sync write with its enable bit clear; a design that wrote through would act on unsynced entries. They also cover a frame from the port an entry does not apply to, trailing payload bytes, which must raise no second strobe, and a write to an address just past the last entry, which must not create an entry.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
   localparam int DA_W     = 48;
   localparam int DA_BYTES = DA_W / 8;
   localparam int DA_HI_W  = DA_W - 32;

   // word addresses
   localparam int ADR_SYNC = 1;
   localparam int ADR_CFG  = 2;
   localparam int ADR_ENT  = 16;
   localparam int ADR_MSK  = 32;
   localparam int MAX_ENT  = (ADR_MSK - ADR_ENT) / 2;

   // upper-word field positions
   localparam int B_APP_P2 = 31;
   localparam int B_APP_P1 = 30;
   localparam int B_PRI    = 19;
   localparam int B_OTH    = 17;
   localparam int B_HOST   = 16;

   // configuration word field positions
   localparam int B_SYNC      = 15;
   localparam int B_UNK_OTH2  = 14;
   localparam int B_UNK_OTH1  = 13;
   localparam int B_UNK_HOST2 = 12;
   localparam int B_UNK_HOST1 = 2;

   typedef struct packed {
      logic            app_p2;
      logic            app_p1;
      logic            pri;
      logic            to_oth;
      logic            to_host;
      logic [DA_W-1:0] addr;
      logic [DA_W-1:0] mask;
   } entry_t;

   typedef struct packed {
      logic oth_p2;
      logic oth_p1;
      logic host_p2;
      logic host_p1;
   } unk_cfg_t;
endpackage

// File: rtl/fwd_regs.sv
module fwd_regs
   import fwd_pkg::*;
#(
   parameter int N_ENT = 4,
   parameter int AW    = 6
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_en,
   input  logic [AW-1:0]            wr_addr,
   input  logic [31:0]              wr_data,
   output entry_t [N_ENT-1:0]       act_ent,
   output unk_cfg_t                 act_cfg,
   output logic                     sync_go
);
   entry_t [N_ENT-1:0] stg_ent;
   unk_cfg_t           stg_cfg;

   assign sync_go = wr_en && (wr_addr == AW'(ADR_SYNC)) && wr_data[B_SYNC];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stg_cfg <= '0;
      end else if (wr_en && (wr_addr == AW'(ADR_CFG))) begin
         stg_cfg.oth_p2  <= wr_data[B_UNK_OTH2];
         stg_cfg.oth_p1  <= wr_data[B_UNK_OTH1];
         stg_cfg.host_p2 <= wr_data[B_UNK_HOST2];
         stg_cfg.host_p1 <= wr_data[B_UNK_HOST1];
      end
   end

   for (genvar i = 0; i < N_ENT; i++) begin : g_stg
      localparam int A_UP = ADR_ENT + 2 * i;
      localparam int M_UP = ADR_MSK + 2 * i;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            stg_ent[i] <= '0;
         end else if (wr_en) begin
            if (wr_addr == AW'(A_UP)) begin
               stg_ent[i].app_p2              <= wr_data[B_APP_P2];
               stg_ent[i].app_p1              <= wr_data[B_APP_P1];
               stg_ent[i].pri                 <= wr_data[B_PRI];
               stg_ent[i].to_oth              <= wr_data[B_OTH];
               stg_ent[i].to_host             <= wr_data[B_HOST];
               stg_ent[i].addr[DA_W-1:32]     <= wr_data[DA_HI_W-1:0];
            end
            if (wr_addr == AW'(A_UP + 1))
               stg_ent[i].addr[31:0] <= wr_data;
            if (wr_addr == AW'(M_UP))
               stg_ent[i].mask[DA_W-1:32] <= wr_data[DA_HI_W-1:0];
            if (wr_addr == AW'(M_UP + 1))
               stg_ent[i].mask[31:0] <= wr_data;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_ent <= '0;
         act_cfg <= '0;
      end else if (sync_go) begin
         act_ent <= stg_ent;
         act_cfg <= stg_cfg;
      end
   end
endmodule

// File: rtl/fwd_da_collect.sv
module fwd_da_collect
   import fwd_pkg::*;
(
   input  logic            clk,
   input  logic            rst_n,
   input  logic            in_vld,
   input  logic            in_sof,
   input  logic            in_port,
   input  logic [7:0]      in_byte,
   output logic [DA_W-1:0] da,
   output logic            da_port,
   output logic            da_rdy
);
   localparam int CW = $clog2(DA_BYTES + 1);

   logic [CW-1:0] cnt_q;
   logic          open;

   assign open = (cnt_q != '0) && (cnt_q < CW'(DA_BYTES));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         da      <= '0;
         da_port <= 1'b0;
         da_rdy  <= 1'b0;
      end else begin
         da_rdy <= 1'b0;
         if (in_vld && in_sof) begin
            da      <= {{(DA_W-8){1'b0}}, in_byte};
            da_port <= in_port;
            cnt_q   <= CW'(1);
         end else if (in_vld && open) begin
            da    <= {da[DA_W-9:0], in_byte};
            cnt_q <= cnt_q + CW'(1);
            if (cnt_q == CW'(DA_BYTES - 1))
               da_rdy <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/fwd_match.sv
module fwd_match
   import fwd_pkg::*;
#(
   parameter int N_ENT    = 4,
   parameter int PIPE_CMP = 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  entry_t [N_ENT-1:0] ent,
   input  logic [DA_W-1:0]    da,
   input  logic               da_port,
   input  logic               da_rdy,
   output logic               m_vld,
   output logic               m_port,
   output logic               m_any,
   output logic               m_host,
   output logic               m_oth,
   output logic               m_pri
);
   logic [N_ENT-1:0] hit, host_v, oth_v, pri_v;
   logic             c_any, c_host, c_oth, c_pri;

   for (genvar i = 0; i < N_ENT; i++) begin : g_cmp
      logic applies;
      assign applies   = da_port ? ent[i].app_p2 : ent[i].app_p1;
      assign hit[i]    = applies && (((da ^ ent[i].addr) & ent[i].mask) == '0);
      assign host_v[i] = ent[i].to_host;
      assign oth_v[i]  = ent[i].to_oth;
      assign pri_v[i]  = ent[i].pri;
   end

   assign c_any  = |hit;
   assign c_host = |(hit & host_v);
   assign c_oth  = |(hit & oth_v);
   assign c_pri  = |(hit & pri_v);

   if (PIPE_CMP != 0) begin : g_pipe
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            m_vld <= 1'b0; m_port <= 1'b0; m_any <= 1'b0;
            m_host <= 1'b0; m_oth <= 1'b0; m_pri <= 1'b0;
         end else begin
            m_vld  <= da_rdy;
            m_port <= da_port;
            m_any  <= c_any;
            m_host <= c_host;
            m_oth  <= c_oth;
            m_pri  <= c_pri;
         end
      end
   end else begin : g_flat
      assign m_vld  = da_rdy;
      assign m_port = da_port;
      assign m_any  = c_any;
      assign m_host = c_host;
      assign m_oth  = c_oth;
      assign m_pri  = c_pri;
   end
endmodule

// File: rtl/fwd_decide.sv
module fwd_decide
   import fwd_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  unk_cfg_t   cfg,
   input  logic       m_vld,
   input  logic       m_port,
   input  logic       m_any,
   input  logic       m_host,
   input  logic       m_oth,
   input  logic       m_pri,
   output logic       dec_vld,
   output logic [1:0] dec_fwd,
   output logic       dec_hit,
   output logic       dec_pri
);
   logic unk_host, unk_oth;

   assign unk_host = m_port ? cfg.host_p2 : cfg.host_p1;
   assign unk_oth  = m_port ? cfg.oth_p2  : cfg.oth_p1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dec_vld <= 1'b0;
         dec_fwd <= 2'b00;
         dec_hit <= 1'b0;
         dec_pri <= 1'b0;
      end else begin
         dec_vld <= m_vld;
         if (m_vld) begin
            dec_hit <= m_any;
            dec_pri <= m_any && m_pri;
            dec_fwd <= m_any ? {m_host, m_oth} : {unk_host, unk_oth};
         end else begin
            dec_hit <= 1'b0;
            dec_pri <= 1'b0;
            dec_fwd <= 2'b00;
         end
      end
   end
endmodule

// File: rtl/fwd_filter.sv
module fwd_filter
   import fwd_pkg::*;
#(
   parameter int N_ENT    = 4,
   parameter int AW       = 6,
   parameter int PIPE_CMP = 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cfg_we,
   input  logic [AW-1:0] cfg_addr,
   input  logic [31:0]   cfg_wdata,
   input  logic          rx_vld,
   input  logic          rx_sof,
   input  logic          rx_port,
   input  logic [7:0]    rx_byte,
   output logic          dec_vld,
   output logic [1:0]    dec_fwd,
   output logic          dec_hit,
   output logic          dec_pri
);
   localparam int LAT = (PIPE_CMP != 0) ? 2 : 1;

   if (N_ENT < 1 || N_ENT > MAX_ENT) begin : g_bad_nent
      $error("fwd_filter: N_ENT out of range");
   end
   if (AW < 6) begin : g_bad_aw
      $error("fwd_filter: AW too small for the register map");
   end
   if (PIPE_CMP < 0 || PIPE_CMP > 1) begin : g_bad_pipe
      $error("fwd_filter: PIPE_CMP must be 0 or 1");
   end

   entry_t [N_ENT-1:0] act_ent;
   unk_cfg_t           act_cfg;
   logic               sync_go;
   logic [DA_W-1:0]    da;
   logic               da_port, da_rdy;
   logic               m_vld, m_port, m_any, m_host, m_oth, m_pri;

   fwd_regs #(.N_ENT(N_ENT), .AW(AW)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(cfg_we), .wr_addr(cfg_addr),
      .wr_data(cfg_wdata), .act_ent(act_ent), .act_cfg(act_cfg), .sync_go(sync_go)
   );

   fwd_da_collect u_col (
      .clk(clk), .rst_n(rst_n), .in_vld(rx_vld), .in_sof(rx_sof),
      .in_port(rx_port), .in_byte(rx_byte), .da(da), .da_port(da_port), .da_rdy(da_rdy)
   );

   fwd_match #(.N_ENT(N_ENT), .PIPE_CMP(PIPE_CMP)) u_match (
      .clk(clk), .rst_n(rst_n), .ent(act_ent), .da(da), .da_port(da_port),
      .da_rdy(da_rdy), .m_vld(m_vld), .m_port(m_port), .m_any(m_any),
      .m_host(m_host), .m_oth(m_oth), .m_pri(m_pri)
   );

   fwd_decide u_dec (
      .clk(clk), .rst_n(rst_n), .cfg(act_cfg), .m_vld(m_vld), .m_port(m_port),
      .m_any(m_any), .m_host(m_host), .m_oth(m_oth), .m_pri(m_pri),
      .dec_vld(dec_vld), .dec_fwd(dec_fwd), .dec_hit(dec_hit), .dec_pri(dec_pri)
   );
endmodule

// File: rtl/fwd_filter_chk.sv
module fwd_filter_chk #(
   parameter int LAT = 2
) (
   input logic       clk,
   input logic       rst_n,
   input logic       da_rdy,
   input logic       sync_go,
   input logic [3:0] act_cfg,
   input logic       dec_vld,
   input logic [1:0] dec_fwd,
   input logic       dec_hit,
   input logic       dec_pri
);
   AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      dec_vld |=> !dec_vld);                                               // R3
   AST_STROBE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      $past(da_rdy, LAT) |-> dec_vld);                                     // R3
   AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !dec_vld |-> (dec_fwd == 2'b00 && !dec_hit && !dec_pri));            // R11
   AST_UNKNOWN_NO_PRI: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_vld && !dec_hit) |-> !dec_pri);                                 // R8
   AST_CFG_ONLY_ON_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(act_cfg) |-> $past(sync_go));                               // R9
endmodule

bind fwd_filter fwd_filter_chk #(.LAT(LAT)) u_chk (
   .clk(clk), .rst_n(rst_n), .da_rdy(da_rdy), .sync_go(sync_go),
   .act_cfg(act_cfg), .dec_vld(dec_vld), .dec_fwd(dec_fwd),
   .dec_hit(dec_hit), .dec_pri(dec_pri)
);

// File: tb/sim_fwd_filter.sv
module sim_fwd_filter;
   localparam int N  = 4;
   localparam int AW = 6;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_we = 1'b0;
   logic [AW-1:0] cfg_addr = '0;
   logic [31:0]   cfg_wdata = '0;
   logic          rx_vld = 1'b0, rx_sof = 1'b0, rx_port = 1'b0;
   logic [7:0]    rx_byte = '0;
   logic          dec_vld, dec_hit, dec_pri;
   logic [1:0]    dec_fwd;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 0;

   // bench model: staged and active words
   logic [31:0] s_up[N], s_lo[N], s_mu[N], s_ml[N], s_cfg;
   logic [31:0] a_up[N], a_lo[N], a_mu[N], a_ml[N], a_cfg;

   fwd_filter #(.N_ENT(N), .AW(AW), .PIPE_CMP(1)) u0 (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .rx_vld(rx_vld), .rx_sof(rx_sof), .rx_port(rx_port),
      .rx_byte(rx_byte), .dec_vld(dec_vld), .dec_fwd(dec_fwd),
      .dec_hit(dec_hit), .dec_pri(dec_pri)
   );

   always #5 clk = ~clk;

   function automatic logic [3:0] model(input logic [47:0] da, input logic p);
      logic h, o, pr, hit;
      h = 0; o = 0; pr = 0; hit = 0;
      for (int i = 0; i < N; i++) begin
         logic [47:0] a, m;
         a = {a_up[i][15:0], a_lo[i]};
         m = {a_mu[i][15:0], a_ml[i]};
         if ((((da ^ a) & m) == 48'd0) && (p ? a_up[i][31] : a_up[i][30])) begin
            hit = 1; h |= a_up[i][16]; o |= a_up[i][17]; pr |= a_up[i][19];
         end
      end
      if (!hit) begin
         h = p ? a_cfg[12] : a_cfg[2];
         o = p ? a_cfg[14] : a_cfg[13];
      end
      return {hit, pr, h, o};
   endfunction

   task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %0h expected %0h", req, got, exp);
      end
   endtask

   task automatic wr(input int adr, input logic [31:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = AW'(adr); cfg_wdata = d;
      for (int i = 0; i < N; i++) begin
         if (adr == 16 + 2*i) s_up[i] = d;
         if (adr == 17 + 2*i) s_lo[i] = d;
         if (adr == 32 + 2*i) s_mu[i] = d;
         if (adr == 33 + 2*i) s_ml[i] = d;
      end
      if (adr == 2) s_cfg = d;
      if (adr == 1 && d[15]) begin
         a_up = s_up; a_lo = s_lo; a_mu = s_mu; a_ml = s_ml; a_cfg = s_cfg;
      end
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic set_ent(input int i, input logic [31:0] up, input logic [31:0] lo,
                          input logic [47:0] m);
      wr(16 + 2*i, up); wr(17 + 2*i, lo);
      wr(32 + 2*i, {16'h0, m[47:32]}); wr(33 + 2*i, m[31:0]);
   endtask

   // sends six DA bytes; returns outputs at the strobe cycle
   task automatic frame(input logic p, input logic [47:0] da, output logic v,
                        output logic [3:0] r);
      for (int b = 0; b < 6; b++) begin
         @(negedge clk);
         rx_vld = 1'b1; rx_sof = (b == 0); rx_port = p;
         rx_byte = da[47 - 8*b -: 8];
      end
      @(negedge clk);
      rx_vld = 1'b0; rx_sof = 1'b0;
      @(posedge clk); @(posedge clk); #1;
      v = dec_vld;
      r = {dec_hit, dec_pri, dec_fwd};
   endtask

   task automatic run(input string req, input logic p, input logic [47:0] da);
      logic v; logic [3:0] r;
      frame(p, da, v, r);
      chk({req, " strobe"}, {31'd0, v}, 32'd1);
      chk(req, {28'd0, r}, {28'd0, model(da, p)});
   endtask

   task automatic tail(input int n);
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         rx_vld = 1'b1; rx_sof = 1'b0; rx_byte = 8'($urandom);
         @(posedge clk); #1;
         chk("R2 tail byte no strobe", {31'd0, dec_vld}, 32'd0);
      end
      @(negedge clk);
      rx_vld = 1'b0;
   endtask

   localparam logic [31:0] AP_BOTH = 32'hC000_0000;
   localparam logic [31:0] HOST = 32'h0001_0000;
   localparam logic [31:0] OTH  = 32'h0002_0000;
   localparam logic [31:0] PRI  = 32'h0008_0000;
   localparam logic [47:0] FULL = 48'hFFFF_FFFF_FFFF;

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      for (int i = 0; i < N; i++) begin
         s_up[i] = 0; s_lo[i] = 0; s_mu[i] = 0; s_ml[i] = 0;
      end
      s_cfg = 0;
      a_up = s_up; a_lo = s_lo; a_mu = s_mu; a_ml = s_ml; a_cfg = s_cfg;

      repeat (4) @(posedge clk);
      #1;
      chk("R1 reset dec_vld", {31'd0, dec_vld}, 32'd0);
      chk("R11 reset outputs", {28'd0, dec_hit, dec_pri, dec_fwd}, 32'd0);
      @(negedge clk); rst_n = 1'b1;

      tail(4);                                             // R2: no open frame
      run("R1 empty table unknown", 1'b0, 48'h0011_2233_4455);

      // R9: staged only
      set_ent(1, AP_BOTH | HOST | 32'h0000_0011, 32'h2233_4455, FULL);
      run("R9 staged not active", 1'b0, 48'h0011_2233_4455);
      wr(1, 32'h0000_7FFF);
      run("R9 sync bit clear", 1'b0, 48'h0011_2233_4455);
      wr(1, 32'h0000_8000);
      run("R10 R6 exact hit host", 1'b0, 48'h0011_2233_4455);
      run("R2 byte order reversed miss", 1'b0, 48'h5544_3322_1100);
      tail(8);                                             // R2 payload ignored
      run("R2 after tail", 1'b1, 48'h0011_2233_4455);

      // R5: apply to port 1 only
      set_ent(1, 32'h4000_0000 | OTH | 32'h0000_0011, 32'h2233_4455, FULL);
      wr(1, 32'h0000_8000);
      run("R5 port1 applies", 1'b0, 48'h0011_2233_4455);
      run("R5 port2 blocked", 1'b1, 48'h0011_2233_4455);

      // R4/R6/R7: multicast and broadcast slots, merge
      set_ent(0, AP_BOTH | HOST | 32'h0000_0100, 32'h0, 48'h0100_0000_0000);
      set_ent(2, AP_BOTH | OTH | PRI | 32'h0000_FFFF, 32'hFFFF_FFFF, FULL);
      wr(1, 32'h0000_8000);
      run("R4 multicast mask", 1'b0, 48'h0300_5E00_0001);
      run("R6 R7 broadcast merge", 1'b1, FULL);
      run("R4 unicast miss", 1'b0, 48'h0200_0000_0001);

      // R8 unknown rules per port
      wr(2, 32'h0000_2004);
      wr(1, 32'h0000_8000);
      run("R8 unknown port1", 1'b0, 48'h0200_0000_0002);
      run("R8 unknown port2", 1'b1, 48'h0200_0000_0002);
      wr(2, 32'h0000_5000);
      wr(1, 32'h0000_8000);
      run("R8 unknown port2 set", 1'b1, 48'h0200_0000_0002);
      run("R8 unknown port1 clear", 1'b0, 48'h0200_0000_0002);

      // R10: address past the table is not an entry
      wr(16 + 2*N, AP_BOTH | HOST | PRI | 32'h0000_0AAA);
      wr(17 + 2*N, 32'hAAAA_AAAA);
      wr(1, 32'h0000_8000);
      run("R10 unmapped write", 1'b0, 48'h0AAA_AAAA_AAAA);

      // R2: restart mid-address
      @(negedge clk); rx_vld = 1; rx_sof = 1; rx_port = 0; rx_byte = 8'hEE;
      @(negedge clk); rx_sof = 0; rx_byte = 8'hEE;
      run("R2 sof restart", 1'b1, FULL);

      // R4 R5 R6 R7 R8: random table and traffic
      for (int it = 0; it < 40; it++) begin
         for (int e = 0; e < N; e++) begin
            logic [47:0] m;
            case ($urandom % 3)
               0: m = FULL;
               1: m = {16'($urandom), 32'($urandom)};
               default: m = {16'h0000, 32'($urandom) | 32'hFFFF_0000};
            endcase
            set_ent(e, ($urandom & 32'hC00B_0000) | (32'($urandom) & 32'h0000_FFFF),
                    32'($urandom), m);
         end
         wr(2, $urandom & 32'h0000_7004);
         wr(1, 32'h0000_8000);
         for (int f = 0; f < 6; f++) begin
            logic [47:0] da;
            int e;
            e = $urandom % N;
            da = {s_up[e][15:0], s_lo[e]};
            if ($urandom % 2) da ^= {16'($urandom), 32'($urandom)} & ~{s_mu[e][15:0], s_ml[e]};
            if ($urandom % 4 == 0) da = {16'($urandom), 32'($urandom)};
            run("R4 R6 random", 1'($urandom), da);
         end
      end

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule